// File: doc/BRIEF.md
# Multi-Channel DMA Interrupt Aggregator

This block gathers single-cycle event pulses from up to sixteen DMA channels and turns them into interrupt state that software can inspect and acknowledge. Events come in three classes: transfer done, first error kind and second error kind. Each class keeps its own sticky pending bits, its own per-channel enable mask, and its own write-ones-to-acknowledge path. Bit i of every vector belongs to channel i.

Enabled pending bits are shown per class. They are also folded into one summary word, in which a channel's bit is set when any of its three classes has an enabled pending event. A single interrupt line follows the OR of the summary word, delayed by one register stage.

Software reaches the block through a plain synchronous register port with a write strobe and a read strobe. Read data is registered and holds its value between reads. The register offsets are fixed, because driver code depends on them.

Top module: `dmairq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all pending bits and all mask bits are zero, `irq_o` is 0 and `reg_rdata_o` is 0.
- R2: A 1 on bit i of an event input sets the pending bit i of that class at the next rising edge. The bit then stays set until it is acknowledged.
- R3: A write to a class's pending register (done 0x600, error-1 0x608, error-2 0x610) clears each pending bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: When an event pulse and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R5: The mask registers (done 0x18, error-1 0x20, error-2 0x24) can be read and written. A mask bit of 1 enables that channel. Bits 16 to 31 read as 0.
- R6: Each class's enabled-status register (done 0x04, error-1 0x0C, error-2 0x10) reads as that class's pending bits ANDed with its mask.
- R7: The summary register at 0x00 has bit i set exactly when channel i has an enabled pending bit in at least one class.
- R8: `irq_o` equals the OR of the summary word as it stood one rising edge earlier.
- R9: Reads of unmapped offsets return 0. Writes to the status, summary or unmapped offsets change no state.
- R10: A read strobe loads `reg_rdata_o` at the next rising edge with the addressed register's value from before that edge. Without a read strobe, `reg_rdata_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_done_i | input | NUM_CH | Transfer-done event pulses, one bit per channel |
| evt_err1_i | input | NUM_CH | First error kind event pulses |
| evt_err2_i | input | NUM_CH | Second error kind event pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An event or a register write takes effect at the rising edge that samples it. A read strobed in the following cycle therefore returns the new value one edge later. `irq_o` reflects a new pending bit two edges after the event: one edge to latch the bit and one edge in the interrupt register. The bench drives every input on the falling edge and keeps a reference model that it advances once per rising edge. It works out the expected read data and interrupt level from the model state as it was before that edge, then compares them on the next falling edge. This keeps every comparison on the exact cycle in which the result is due.

// File: rtl/dmairq_pkg.sv
// Package: shared constants and register-offset functions for the DMA
// interrupt aggregator. Assumes byte offsets fit in 12 bits.
package dmairq_pkg;

    localparam int NCLS = 3;   // done, error-1, error-2 (index = class)
    localparam int OFFW = 12;

    localparam logic [OFFW-1:0] OFF_SUMMARY = 12'h000;

    // Offset of the enabled-status register of class c.
    function automatic logic [OFFW-1:0] status_off(input int c);
        case (c)
            0:       return 12'h004;
            1:       return 12'h00C;
            default: return 12'h010;
        endcase
    endfunction

    // Offset of the mask register of class c.
    function automatic logic [OFFW-1:0] mask_off(input int c);
        case (c)
            0:       return 12'h018;
            1:       return 12'h020;
            default: return 12'h024;
        endcase
    endfunction

    // Offset of the pending (acknowledge) register of class c.
    function automatic logic [OFFW-1:0] pend_off(input int c);
        return 12'h600 + OFFW'(8 * c);
    endfunction

endpackage

// File: rtl/dmairq_evt_bank.sv
// Module: one event class. It holds the sticky pending bits and the enable
// mask for NUM_CH channels. Assumes event inputs are already synchronous
// to clk. A new event wins over an acknowledge of the same bit.
module dmairq_evt_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic [NUM_CH-1:0] ack_i,
    input  logic              mask_we_i,
    input  logic [NUM_CH-1:0] mask_wdata_i,
    output logic [NUM_CH-1:0] pend_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] enabled_o
);

    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] mask_q;

    // Pending bits: clear the acknowledged bits, then set the new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_i) | evt_i;
    end

    // Mask register: loaded whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    assign pend_o    = pend_q;
    assign mask_o    = mask_q;
    assign enabled_o = pend_q & mask_q;

endmodule

// File: rtl/dmairq_reg_port.sv
// Module: address decode and registered read mux for the aggregator.
// Assumes NUM_CH < DATA_W and that at most one access is made per cycle.
// A read returns the state from before the edge that samples the strobe.
module dmairq_reg_port
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic                        rd_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [NCLS-1:0][NUM_CH-1:0] pend_i,
    input  logic [NCLS-1:0][NUM_CH-1:0] mask_i,
    input  logic [NCLS-1:0][NUM_CH-1:0] enabled_i,
    input  logic [NUM_CH-1:0]           summary_i,
    output logic [NCLS-1:0]             mask_we_o,
    output logic [NUM_CH-1:0]           mask_wdata_o,
    output logic [NCLS-1:0][NUM_CH-1:0] ack_o,
    output logic [DATA_W-1:0]           rdata_o
);

    logic [NCLS-1:0]   hit_status;
    logic [NCLS-1:0]   hit_mask;
    logic [NCLS-1:0]   hit_pend;
    logic              hit_summary;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_wdata_hi;

    assign hit_summary     = (addr_i == ADDR_W'(OFF_SUMMARY));
    assign mask_wdata_o    = wdata_i[NUM_CH-1:0];
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_CH];

    // Per-class decode: one set of compares for each class.
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign hit_status[c] = (addr_i == ADDR_W'(status_off(c)));
        assign hit_mask[c]   = (addr_i == ADDR_W'(mask_off(c)));
        assign hit_pend[c]   = (addr_i == ADDR_W'(pend_off(c)));
        assign mask_we_o[c]  = wr_i & hit_mask[c];
        assign ack_o[c]      = (wr_i && hit_pend[c]) ? wdata_i[NUM_CH-1:0] : '0;
    end

    // Read mux: select the addressed word, zero for unmapped offsets.
    always_comb begin
        rd_next = '0;
        if (hit_summary) rd_next = DATA_W'(summary_i);
        for (int c = 0; c < NCLS; c++) begin
            if (hit_status[c]) rd_next = DATA_W'(enabled_i[c]);
            if (hit_mask[c])   rd_next = DATA_W'(mask_i[c]);
            if (hit_pend[c])   rd_next = DATA_W'(pend_i[c]);
        end
    end

    // Read data register: loads on a read strobe, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_next;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/dmairq_irq_merge.sv
// Module: folds the enabled bits of every class into the per-channel
// summary word and registers the OR of that word as the interrupt line.
module dmairq_irq_merge
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCLS-1:0][NUM_CH-1:0] enabled_i,
    output logic [NUM_CH-1:0]           summary_o,
    output logic                        irq_o
);

    logic irq_q;

    // Summary: per-channel OR across all classes.
    always_comb begin
        summary_o = '0;
        for (int c = 0; c < NCLS; c++) summary_o = summary_o | enabled_i[c];
    end

    // Interrupt register: one stage after the summary word.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |summary_o;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/dmairq_ctrl.sv
// Module: top of the DMA interrupt aggregator. It instantiates one event
// bank per class, the register port and the interrupt merge stage.
// Assumes a synchronous active-low reset and single-cycle event pulses.
module dmairq_ctrl
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_done_i,
    input  logic [NUM_CH-1:0] evt_err1_i,
    input  logic [NUM_CH-1:0] evt_err2_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    logic [NCLS-1:0][NUM_CH-1:0] evt_bus;
    logic [NCLS-1:0][NUM_CH-1:0] ack_bus;
    logic [NCLS-1:0][NUM_CH-1:0] pend_bus;
    logic [NCLS-1:0][NUM_CH-1:0] mask_bus;
    logic [NCLS-1:0][NUM_CH-1:0] enabled_bus;
    logic [NCLS-1:0]             mask_we;
    logic [NUM_CH-1:0]           mask_wdata;
    logic [NUM_CH-1:0]           summary;

    assign evt_bus[0] = evt_done_i;
    assign evt_bus[1] = evt_err1_i;
    assign evt_bus[2] = evt_err2_i;

    for (genvar c = 0; c < NCLS; c++) begin : g_bank
        dmairq_evt_bank #(.NUM_CH(NUM_CH)) bank_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .evt_i        (evt_bus[c]),
            .ack_i        (ack_bus[c]),
            .mask_we_i    (mask_we[c]),
            .mask_wdata_i (mask_wdata),
            .pend_o       (pend_bus[c]),
            .mask_o       (mask_bus[c]),
            .enabled_o    (enabled_bus[c])
        );
    end

    dmairq_reg_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr_i),
        .rd_i         (reg_rd_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .pend_i       (pend_bus),
        .mask_i       (mask_bus),
        .enabled_i    (enabled_bus),
        .summary_i    (summary),
        .mask_we_o    (mask_we),
        .mask_wdata_o (mask_wdata),
        .ack_o        (ack_bus),
        .rdata_o      (reg_rdata_o)
    );

    dmairq_irq_merge #(.NUM_CH(NUM_CH)) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enabled_i (enabled_bus),
        .summary_o (summary),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/dmairq_ctrl_chk.sv
// Checker: timing properties of the aggregator, bound into dmairq_ctrl.
// The class vectors are viewed flat, NCLS*NUM_CH bits wide.
module dmairq_ctrl_chk #(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32,
    parameter int FLAT   = 3 * NUM_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FLAT-1:0]   evt,
    input logic [FLAT-1:0]   ack,
    input logic [FLAT-1:0]   pend,
    input logic [FLAT-1:0]   mask,
    input logic [NUM_CH-1:0] summary,
    input logic              rd,
    input logic [DATA_W-1:0] rdata,
    input logic              irq
);

    // R2 / R4: every event bit is pending on the next cycle, acknowledged or not.
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

    // R2: a pending bit that is not acknowledged stays set.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~ack) != '0) |=> ((pend & $past(pend & ~ack)) == $past(pend & ~ack)));

    // R3: an acknowledged bit with no new event is clear on the next cycle.
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack & ~evt) != '0) |=> ((pend & $past(ack & ~evt)) == '0));

    // R7: a nonzero summary needs some enabled mask bit.
    a_r7_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (summary != '0) |-> (mask != '0));

    // R8: the interrupt line follows the summary word one cycle later.
    a_r8_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        (summary != '0) |=> irq);
    a_r8_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        (summary == '0) |=> !irq);

    // R10: without a read strobe the read data holds.
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

bind dmairq_ctrl dmairq_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_bus),
    .ack     (ack_bus),
    .pend    (pend_bus),
    .mask    (mask_bus),
    .summary (summary),
    .rd      (reg_rd_i),
    .rdata   (reg_rdata_o),
    .irq     (irq_o)
);

// File: tb/dmairq_ctrl_tb.sv
// Bench: directed corner cases followed by seeded random traffic, all
// compared against a reference model kept in the bench.
module dmairq_ctrl_tb_top;

    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] e_done, e_err1, e_err2;
    logic        wr, rd;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] m_pend [3];
    logic [15:0] m_mask [3];
    logic [31:0] m_rdata;

    always #10 clk = ~clk;   // 50 MHz

    dmairq_ctrl #(.NUM_CH(NCH)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_done_i  (e_done),
        .evt_err1_i  (e_err1),
        .evt_err2_i  (e_err2),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [15:0] m_summary();
        return (m_pend[0] & m_mask[0]) | (m_pend[1] & m_mask[1]) | (m_pend[2] & m_mask[2]);
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return {16'h0, m_summary()};
            12'h004: return {16'h0, m_pend[0] & m_mask[0]};
            12'h00C: return {16'h0, m_pend[1] & m_mask[1]};
            12'h010: return {16'h0, m_pend[2] & m_mask[2]};
            12'h018: return {16'h0, m_mask[0]};
            12'h020: return {16'h0, m_mask[1]};
            12'h024: return {16'h0, m_mask[2]};
            12'h600: return {16'h0, m_pend[0]};
            12'h608: return {16'h0, m_pend[1]};
            12'h610: return {16'h0, m_pend[2]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // One clock cycle: drive at the falling edge, advance the model over the
    // rising edge, compare at the next falling edge.
    task automatic cyc(input logic [15:0] ed, input logic [15:0] e1, input logic [15:0] e2,
                       input logic w, input logic r, input logic [11:0] a,
                       input logic [31:0] d, input string tag);
        logic [15:0] evs [3];
        logic [31:0] exp_rd;
        logic        exp_irq;
        e_done = ed; e_err1 = e1; e_err2 = e2;
        wr = w; rd = r; addr = a; wdata = d;
        evs[0] = ed; evs[1] = e1; evs[2] = e2;
        exp_rd  = r ? m_read(a) : m_rdata;
        exp_irq = |m_summary();
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            logic [15:0] ackv;
            ackv = (w && a == 12'h600 + 12'(8 * c)) ? d[15:0] : 16'h0;
            m_pend[c] = (m_pend[c] & ~ackv) | evs[c];
        end
        if (w && a == 12'h018) m_mask[0] = d[15:0];
        if (w && a == 12'h020) m_mask[1] = d[15:0];
        if (w && a == 12'h024) m_mask[2] = d[15:0];
        m_rdata = exp_rd;
        check("R8 irq", {31'h0, irq}, {31'h0, exp_irq});
        if (r) check(tag, rdata, exp_rd);
        else   check("R10 hold", rdata, exp_rd);
    endtask

    task automatic rd_reg(input logic [11:0] a, input string tag);
        cyc(16'h0, 16'h0, 16'h0, 1'b0, 1'b1, a, 32'h0, tag);
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(16'h0, 16'h0, 16'h0, 1'b1, 1'b0, a, d, tag);
    endtask

    task automatic idle();
        cyc(16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 12'h0, 32'h0, "R10");
    endtask

    task automatic summary_line();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary_line();
            $finish;
        end
    end

    localparam logic [11:0] ADDRS [11] = '{12'h000, 12'h004, 12'h00C, 12'h010, 12'h018,
                                           12'h020, 12'h024, 12'h600, 12'h608, 12'h610, 12'h100};

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0;
        e_done = '0; e_err1 = '0; e_err2 = '0;
        wr = 0; rd = 0; addr = '0; wdata = '0;
        for (int c = 0; c < 3; c++) begin m_pend[c] = '0; m_mask[c] = '0; end
        m_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports and in every register
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 rdata", rdata, 32'h0);
        for (int i = 0; i < 10; i++) rd_reg(ADDRS[i], "R1 reset value");

        // R5: mask read/write, upper bits read as zero
        wr_reg(12'h018, 32'hFFFF_FFFF, "R5");
        rd_reg(12'h018, "R5 mask all ones");
        wr_reg(12'h020, 32'h0000_0000, "R5");
        rd_reg(12'h020, "R5 mask zero");

        // R2: events latch and stay
        cyc(16'h0005, 16'h0, 16'h0, 1'b0, 1'b0, 12'h0, 32'h0, "R2");
        idle();
        rd_reg(12'h600, "R2 pending held");

        // R6: enabled status follows the mask
        rd_reg(12'h004, "R6 status full mask");
        wr_reg(12'h018, 32'h0000_0001, "R6");
        rd_reg(12'h004, "R6 status partial mask");

        // R7: summary across classes
        cyc(16'h0, 16'h0, 16'h0100, 1'b0, 1'b0, 12'h0, 32'h0, "R7");
        rd_reg(12'h000, "R7 summary masked err2");
        wr_reg(12'h024, 32'h0000_0100, "R7");
        rd_reg(12'h000, "R7 summary two classes");

        // R3: write-ones acknowledge, zeros keep
        wr_reg(12'h600, 32'h0000_0004, "R3");
        rd_reg(12'h600, "R3 partial ack");

        // R4: event and acknowledge of the same bit together
        cyc(16'h0001, 16'h0, 16'h0, 1'b1, 1'b0, 12'h600, 32'h0000_0001, "R4");
        rd_reg(12'h600, "R4 set wins");

        // R9: writes to read-only or unmapped offsets have no effect
        wr_reg(12'h004, 32'hFFFF_FFFF, "R9");
        wr_reg(12'h000, 32'hFFFF_FFFF, "R9");
        wr_reg(12'h100, 32'hFFFF_FFFF, "R9");
        rd_reg(12'h600, "R9 pending unchanged");
        rd_reg(12'h018, "R9 mask unchanged");
        rd_reg(12'h100, "R9 unmapped reads zero");

        // R8: acknowledge everything and let irq fall
        wr_reg(12'h600, 32'h0000_FFFF, "R8");
        wr_reg(12'h610, 32'h0000_FFFF, "R8");
        idle();
        idle();

        // Random traffic over all requirements
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a0, a1, a2;
            logic        w, r;
            logic [11:0] a;
            logic [31:0] d;
            a0 = 16'($urandom) & 16'($urandom) & 16'($urandom);
            a1 = 16'($urandom) & 16'($urandom) & 16'($urandom) & 16'($urandom);
            a2 = 16'($urandom) & 16'($urandom) & 16'($urandom) & 16'($urandom);
            w  = ($urandom % 3) == 0;
            r  = ($urandom % 2) == 0;
            a  = ADDRS[$urandom % 11];
            d  = $urandom;
            cyc(a0, a1, a2, w, r, a, d, "R6 R7 R9 random read");
        end

        finished = 1;
        summary_line();
        $finish;
    end

endmodule